// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a ring of transmit descriptors that software prepares in a small internal dual-port RAM, and sends one buffer per descriptor as a byte stream. Each descriptor is two 32-bit words. The first holds the start address of the buffer in the packet buffer memory. The second holds a length, an end-of-frame flag, a wrap flag and an ownership flag. Software clears the ownership flag to queue a buffer. The block sets the flag again once the buffer has been sent, which hands the descriptor back to software.

A start pulse makes the block fetch the descriptor at its current index. If that descriptor is still owned by software, the block goes idle and keeps the index where it is. Otherwise it streams the buffer bytes over a valid/ready output, writes the descriptor back and moves to the next index. The next index is either the following slot or the queue base index, if the wrap flag is set.

A start pulse that arrives while the block is busy is remembered. It buys one more look at the ring after the block would otherwise stop. Dropping the enable input stops the block and returns the index to the queue base. The buffer memory port has an availability input. If the data is missing while the sink is ready, the frame ends in an underrun.

Top module: `tx_ring_reader`

## Requirements
- R1: While reset is held and after it is released, `busy`, `tx_valid`, `tx_done` and `tx_underrun` are 0 and `cur_idx` equals `queue_base`.
- R2: Descriptor i occupies RAM word 2*i (buffer address in bits [BUF_AW-1:0]) and word 2*i+1 (control). In the control word, bits [LEN_W-1:0] are the length, bit 15 is end-of-frame, bit 30 is wrap and bit 31 is used. On a start pulse with `tx_en` high, the descriptor at `cur_idx` is fetched. If its used bit is 0, exactly length bytes are sent in order, byte k being `buf_data` for `buf_addr` = address + k, one byte per cycle where `tx_valid` and `tx_ready` are both high. A length of 0 sends no byte.
- R3: `tx_last` is high on the final byte of a descriptor only when its end-of-frame bit is set. `tx_done` pulses once per such descriptor after its final byte and never for a descriptor without that bit.
- R4: After its bytes, a descriptor's control word reads back through the software port with bit 31 set and all other bits unchanged. The software port reads with one cycle of latency, and the block's write-back wins a same-word collision.
- R5: A fetched descriptor whose used bit is 1 makes the block go idle with no byte sent and `cur_idx` left at that descriptor.
- R6: After a descriptor is handed back, `cur_idx` becomes `queue_base` if its wrap bit is set, and otherwise the next index modulo NDESC. The block then fetches that descriptor.
- R7: A start pulse while `busy` is high is recorded. When the scan meets a used descriptor, one further fetch of that same descriptor follows, which lengthens the busy time by exactly 3 cycles.
- R8: With `tx_en` low, the block is idle, `cur_idx` follows `queue_base`, start pulses are ignored and a recorded start is dropped.
- R9: If `tx_ready` is high while `buf_ok` is low during a frame, `tx_underrun` pulses for that cycle, no further byte is sent and the descriptor is handed back with its used bit set. `tx_done` is not raised, `cur_idx` advances as in R6 and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable level |
| tx_start | input | 1 | Start / resume pulse |
| queue_base | input | IW | Ring base index used on wrap and disable |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_addr | input | IW+1 | Software descriptor word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, one cycle latency |
| buf_addr | output | BUF_AW | Packet buffer byte address |
| buf_data | input | 8 | Packet buffer byte at buf_addr |
| buf_ok | input | 1 | Packet buffer byte is available |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts a byte |
| tx_done | output | 1 | Frame complete pulse |
| tx_underrun | output | 1 | Underrun pulse |
| busy | output | 1 | Block is scanning or sending |
| cur_idx | output | IW | Current descriptor index |

## Verification
Two events can fall in the same cycle: a fresh start pulse while the block is already working, and the fetch that finds a used descriptor and would send the block idle. The bench issues a second start a few cycles into a frame, so the start is recorded and consumed by that later check. It then compares the busy duration against an identical run without the extra pulse and expects exactly three more cycles. Underrun and end-of-frame completion also compete for the same descriptor write-back. The bench judges that case by the `tx_done` and `tx_underrun` counts and by reading the control word back.

// File: rtl/tx_ring_reader.sv
module tx_ring_reader #(
  parameter int NDESC  = 8,
  parameter int BUF_AW = 12,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_start,
  input  logic [$clog2(NDESC)-1:0] queue_base,
  input  logic              sw_we,
  input  logic [$clog2(NDESC):0]   sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  input  logic              buf_ok,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              tx_done,
  output logic              tx_underrun,
  output logic              busy,
  output logic [$clog2(NDESC)-1:0] cur_idx
);
  localparam int IW       = $clog2(NDESC);
  localparam int EOF_BIT  = 15;
  localparam int WRAP_BIT = 30;
  localparam int USED_BIT = 31;

  typedef enum logic [2:0] {S_IDLE, S_RA, S_RC, S_CHK, S_SEND, S_WB} st_t;

  st_t              state;
  logic [IW-1:0]    ptr;
  logic             pend;
  logic             urun;
  logic [BUF_AW-1:0] baddr;
  logic [31:0]      ctrl;
  logic [LEN_W-1:0] cnt;
  logic [31:0]      mem [2*NDESC];
  logic [31:0]      q;
  logic [IW:0]      rd_addr;
  logic             wb_we;
  logic [31:0]      wb_data;
  logic [LEN_W-1:0] len;
  logic             last_byte;
  logic             fire;
  logic [IW-1:0]    ptr_next;

  assign len       = ctrl[LEN_W-1:0];
  assign last_byte = (cnt == len - 1'b1);
  assign fire      = (state == S_SEND) && tx_ready && buf_ok;
  assign rd_addr   = {ptr, (state == S_RC) || (state == S_WB)};
  assign wb_we     = (state == S_WB);
  assign wb_data   = ctrl | (32'd1 << USED_BIT);
  assign ptr_next  = ctrl[WRAP_BIT] ? queue_base :
                     (ptr == IW'(NDESC - 1)) ? '0 : ptr + 1'b1;

  assign buf_addr    = baddr + BUF_AW'(cnt);
  assign tx_data     = buf_data;
  assign tx_valid    = (state == S_SEND) && buf_ok;
  assign tx_last     = (state == S_SEND) && ctrl[EOF_BIT] && last_byte;
  assign tx_done     = (state == S_WB) && ctrl[EOF_BIT] && !urun;
  assign tx_underrun = (state == S_SEND) && tx_ready && !buf_ok;
  assign busy        = (state != S_IDLE);
  assign cur_idx     = ptr;

  always_ff @(posedge clk) begin
    if (sw_we && !(wb_we && sw_addr == rd_addr)) mem[sw_addr] <= sw_wdata;
    if (wb_we) mem[rd_addr] <= wb_data;
    sw_rdata <= mem[sw_addr];
    q        <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      state <= S_IDLE;
      ptr   <= queue_base;
      pend  <= 1'b0;
      urun  <= 1'b0;
      baddr <= '0;
      ctrl  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (tx_start || pend) begin
          state <= S_RA;
          pend  <= 1'b0;
        end
        S_RA:  state <= S_RC;
        S_RC: begin
          baddr <= q[BUF_AW-1:0];
          state <= S_CHK;
        end
        S_CHK: begin
          if (q[USED_BIT]) begin
            state <= pend ? S_RA : S_IDLE;
            pend  <= 1'b0;
          end else begin
            ctrl  <= q;
            cnt   <= '0;
            urun  <= 1'b0;
            state <= (q[LEN_W-1:0] == '0) ? S_WB : S_SEND;
          end
        end
        S_SEND: begin
          if (fire) begin
            if (last_byte) state <= S_WB;
            else cnt <= cnt + 1'b1;
          end else if (tx_ready) begin
            urun  <= 1'b1;
            state <= S_WB;
          end
        end
        S_WB: begin
          ptr   <= ptr_next;
          state <= urun ? S_IDLE : S_RA;
        end
        default: state <= S_IDLE;
      endcase
      if (tx_start && state != S_IDLE) pend <= 1'b1;
    end
  end

  p_valid_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);
  p_done_not_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_underrun);
  p_underrun_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> !tx_valid);
  p_disable_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !busy && cur_idx == $past(queue_base));
  p_idle_keeps_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_en) |=> $stable(cur_idx));
  p_last_is_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && tx_ready && buf_ok) |=> !tx_valid);
endmodule

// File: tb/tx_ring_reader_tb.sv
module tx_ring_reader_tb;
  localparam int NDESC = 8;
  localparam int IW = 3;
  localparam int BUF_AW = 12;

  logic clk = 0, rst_n = 0, tx_en = 0, tx_start = 0, sw_we = 0, tx_ready = 1;
  logic [IW-1:0] queue_base = '0;
  logic [IW:0] sw_addr = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0] buf_data, tx_data;
  logic buf_ok, tx_valid, tx_last, tx_done, tx_underrun, busy;
  logic [IW-1:0] cur_idx;
  logic fail_en = 0;
  logic [BUF_AW-1:0] fail_addr = '0;

  assign buf_data = buf_addr[7:0] ^ 8'hA5;
  assign buf_ok   = !(fail_en && buf_addr == fail_addr);

  always #5 clk = ~clk;

  tx_ring_reader #(.NDESC(NDESC), .BUF_AW(BUF_AW), .LEN_W(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start), .queue_base(queue_base),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .buf_addr(buf_addr), .buf_data(buf_data), .buf_ok(buf_ok),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_done(tx_done), .tx_underrun(tx_underrun), .busy(busy), .cur_idx(cur_idx));

  int n_chk = 0, n_bad = 0;
  logic [7:0] cap [64];
  logic cap_last [64];
  int ncap = 0, nlast = 0, ndone = 0, nur = 0;

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      cap[ncap[5:0]] <= tx_data;
      cap_last[ncap[5:0]] <= tx_last;
      ncap <= ncap + 1;
    end
    if (tx_last && tx_valid && tx_ready) nlast <= nlast + 1;
    if (tx_done) ndone <= ndone + 1;
    if (tx_underrun) nur <= nur + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1 sw_we = 1; sw_addr = (IW+1)'(a); sw_wdata = d;
    @(posedge clk); #1 sw_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(posedge clk); #1 sw_addr = (IW+1)'(a);
    @(posedge clk); #1 d = sw_rdata;
  endtask

  task automatic put(input int i, input logic [31:0] a, input logic [31:0] c);
    wr(2*i, a); wr(2*i+1, c);
  endtask

  task automatic clr;
    @(posedge clk); #1 ncap = 0; nlast = 0; ndone = 0; nur = 0;
  endtask

  task automatic go_wait(input bit extra, output int nbusy);
    int cyc = 0;
    nbusy = 0;
    @(posedge clk); #1 tx_start = 1;
    @(posedge clk); #1 tx_start = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      nbusy++; cyc++;
      tx_start = (extra && cyc == 2);
    end
    tx_start = 0;
  endtask

  task automatic en_cycle(input logic [IW-1:0] b);
    @(posedge clk); #1 tx_en = 0; queue_base = b;
    @(posedge clk); @(posedge clk); #1 tx_en = 1;
  endtask

  localparam logic [31:0] VEC [4] = '{32'h0010_0001, 32'h00F0_0005, 32'h03FE_0004, 32'h0123_0009};

  initial begin
    logic [31:0] rv;
    int nb, na, nb2, okb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !tx_valid && !tx_done && !tx_underrun, "R1 idle outputs", busy, 0);
    chk(cur_idx == 0, "R1 cur_idx=base", cur_idx, 0);
    #1 rst_n = 1; tx_en = 1;
    for (int i = 0; i < NDESC; i++) put(i, 32'h0, 32'h8000_0000);

    for (int v = 0; v < 4; v++) begin
      logic [31:0] a = {20'h0, VEC[v][27:16]};
      int l = int'(VEC[v][15:0]);
      clr();
      put(v, a, 32'h0000_8000 | 32'(l));
      go_wait(0, nb);
      chk(ncap == l, "R2 byte count", ncap, l);
      okb = 1;
      for (int k = 0; k < l; k++)
        if (cap[k] !== (8'(a + 32'(k)) ^ 8'hA5)) okb = 0;
      chk(okb == 1, "R2 byte order/value", okb, 1);
      chk(cap_last[l-1] == 1 && nlast == 1, "R3 tx_last on final byte", nlast, 1);
      chk(ndone == 1, "R3 tx_done once", ndone, 1);
      rd(2*v+1, rv);
      chk(rv == (32'h8000_8000 | 32'(l)), "R4 write-back", int'(rv), int'(32'h8000_8000 | 32'(l)));
      chk(cur_idx == IW'(v+1), "R6 next index", cur_idx, v+1);
    end

    clr(); go_wait(0, nb);
    chk(ncap == 0 && cur_idx == 4, "R5 used descriptor stops, index kept", cur_idx, 4);

    clr();
    put(4, 32'h20, 32'h0000_0002);
    put(5, 32'h40, 32'h0000_8003);
    go_wait(0, nb);
    chk(ncap == 5 && nlast == 1 && cap_last[4] == 1, "R3 multi-buffer last", nlast, 1);
    chk(ndone == 1, "R3 no done without eof flag", ndone, 1);
    chk(cur_idx == 6, "R6 chain index", cur_idx, 6);

    clr();
    put(6, 32'h60, 32'h4000_8001);
    go_wait(0, nb);
    chk(ncap == 1 && cur_idx == 0, "R6 wrap to base", cur_idx, 0);

    @(posedge clk); #1 tx_en = 0; queue_base = 3;
    @(posedge clk); @(posedge clk); #1 tx_start = 1;
    @(posedge clk); #1 tx_start = 0;
    @(negedge clk);
    chk(cur_idx == 3, "R8 index follows base", cur_idx, 3);
    chk(!busy && ncap == 1, "R8 start ignored when disabled", busy, 0);
    #1 tx_en = 1;

    clr();
    put(3, 32'h80, 32'h0000_8006);
    @(posedge clk); #1 fail_en = 1; fail_addr = 12'h082;
    go_wait(0, nb);
    #1 fail_en = 0;
    chk(ncap == 2, "R9 bytes before underrun", ncap, 2);
    chk(nur == 1 && ndone == 0 && nlast == 0, "R9 underrun pulse, no done", nur, 1);
    rd(7, rv);
    chk(rv == 32'h8000_8006, "R9 descriptor handed back", int'(rv), int'(32'h8000_8006));
    chk(cur_idx == 4 && !busy, "R9 idle, index advanced", cur_idx, 4);

    en_cycle(0);
    clr(); put(0, 32'h0, 32'h0000_8004);
    go_wait(0, na);
    en_cycle(0);
    clr(); put(0, 32'h0, 32'h0000_8004);
    go_wait(1, nb2);
    chk(ncap == 4, "R7 frame sent with extra start", ncap, 4);
    chk(nb2 == na + 3, "R7 one extra scan", nb2, na + 3);

    clr(); put(1, 32'h0, 32'h0000_8000);
    go_wait(0, nb);
    chk(ncap == 0 && ndone == 1, "R2 zero length sends nothing", ncap, 0);
    rd(3, rv);
    chk(rv == 32'h8000_8000 && cur_idx == 2, "R4 zero length write-back", int'(rv), int'(32'h8000_8000));

    summary();
  end
endmodule